// File: doc/BRIEF.md
# Uplink Command Packet Framer

This block sits behind a serial command receiver that hands over one 16-bit command word at a time. Every arriving word is stored in a word FIFO, whether or not packet tracking is enabled. When software turns the packet tracker on, the tracker reads the stream as length-prefixed packets. The first word it sees is a length N. The next N words are the body of the packet. After the last body word the tracker raises a packet-done cause, and the word that follows is read as the length of the next packet. Each FIFO entry carries a flag that marks the word the tracker took as a length, so software can find packet boundaries while it drains the FIFO.

Software reads the FIFO through one 32-bit data port. A read strobe pops the head word. A flush pulse empties the FIFO. Three sticky causes are kept: packet done, zero-length error and overflow. They drive a single interrupt line, and one acknowledge pulse clears all three.

Top module: `uplink_framer`

## Requirements
- R1: When the FIFO is not full, every word presented with `word_valid_i` is stored, whatever the tracker's enable. Words read back in arrival order.
- R2: `rd_data_o` holds the head word in bits 15:0, the first-word flag in bit 16, and a not-empty flag in bit 31. Bits 30:17 always read zero. When the FIFO is empty, bits 16:0 also read zero.
- R3: While `ctrl_enable_i` is high and the tracker is waiting for a length, the arriving word is stored with bit 16 set. All other words are stored with bit 16 clear. While the tracker is disabled, no word changes the done or length-error causes.
- R4: After a nonzero length N, the Nth following word sets the done cause (`status_o[0]`). The cause is visible on the clock edge that takes in that word. It stays set until it is acknowledged.
- R5: The word after a completed packet is taken as the next length and stored with bit 16 set.
- R6: A length word of zero sets the length-error cause (`status_o[1]`). It is stored with bit 16 set, and the next word is again taken as a length.
- R7: A word that arrives while the FIFO holds `FIFO_DEPTH` entries is dropped, sets the overflow cause (`status_o[2]`), and leaves the FIFO contents unchanged.
- R8: A read strobe pops one entry only when the FIFO is not empty. A strobe on an empty FIFO has no effect.
- R9: A `fifo_reset_i` pulse empties the FIFO on the next edge. It takes precedence over a word written in the same cycle, and the tracker still counts that word.
- R10: `irq_o` is high whenever any cause is set. `irq_clear_i` clears all causes, but a cause raised in the same cycle stays set.
- R11: Dropping `ctrl_enable_i` for at least one edge abandons a partly received packet. After re-enabling, the next word is taken as a length.
- R12: After reset the FIFO is empty, all causes are clear, `irq_o` is low, and the tracker waits for a length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid_i | input | 1 | A command word is presented this cycle |
| word_i | input | 16 | Command word from the receiver |
| ctrl_enable_i | input | 1 | Enables packet tracking |
| rd_strobe_i | input | 1 | Data port read, pops the head entry |
| rd_data_o | output | 32 | {not-empty, 14'b0, first-word flag, word} |
| fifo_reset_i | input | 1 | Pulse that empties the FIFO |
| irq_clear_i | input | 1 | Pulse that acknowledges all causes |
| status_o | output | 3 | Sticky causes {overflow, length error, done} |
| irq_o | output | 1 | Interrupt request, OR of the causes |

## Verification
The assertions check on every cycle the fixed-zero bits and the empty-read value of the data port, that the FIFO fill never exceeds its depth and holds when a word arrives at a full FIFO, that a flush and an empty-FIFO read behave as described, that the causes stay sticky, that an acknowledge clears them, and that the tracker is quiet while disabled. Only the bench scenarios can show the packet framing itself. These cover completion on exactly the Nth body word for a sweep of lengths, first-word flags landing on the right entries, recovery after a zero length, a packet abandoned by disabling, the order of the data under wrap-around, and a cause raised in the same cycle as an acknowledge.

// File: rtl/uplink_pkg.sv
// Shared types for the uplink command framer.
// Assumes 16-bit command words; one FIFO entry is a word plus its first-word flag.
package uplink_pkg;
    localparam int WORD_W = 16;

    // Position of each sticky cause in the status vector
    localparam int CAUSE_DONE = 0;
    localparam int CAUSE_LERR = 1;
    localparam int CAUSE_OVF  = 2;
    localparam int CAUSE_N    = 3;

    typedef struct packed {
        logic              first;
        logic [WORD_W-1:0] word;
    } cmd_entry_t;
endpackage

// File: rtl/uplink_fifo.sv
// Word FIFO with flush. Push is ignored while full; pop is ignored while empty;
// flush wins over push and pop in the same cycle.
// Assumes DEPTH >= 2. Pointers wrap explicitly, so DEPTH need not be a power of two.
module uplink_fifo
    import uplink_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  cmd_entry_t                   din_i,
    input  logic                         pop_i,
    output cmd_entry_t                   head_o,
    output logic                         empty_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    cmd_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic             push_ok, pop_ok;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign push_ok = push_i && !full_o && !flush_i;
    assign pop_ok  = pop_i && !empty_o && !flush_i;
    assign head_o  = mem[rd_ptr];
    assign count_o = count_q;

    // Store the incoming entry at the write pointer
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din_i;
    end

    // Advance pointers and the fill count
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + PTR_W'(1);
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/uplink_tracker.sv
// Packet tracker: while enabled, reads the word stream as a length followed by
// that many body words. Flags the length word, pulses done on the last body word,
// and pulses a length error on a zero length. Disable returns it to length-wait.
// Assumes at most one word per cycle; every received word counts, stored or not.
module uplink_tracker
    import uplink_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              first_o,
    output logic              done_o,
    output logic              len_err_o
);
    logic              await_len;
    logic [WORD_W-1:0] remain;

    assign first_o   = enable_i && await_len;
    assign len_err_o = enable_i && word_valid_i && await_len && (word_i == '0);
    assign done_o    = enable_i && word_valid_i && !await_len && (remain == WORD_W'(1));

    // Follow the length and body words of the current packet
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            await_len <= 1'b1;
            remain    <= '0;
        end else if (word_valid_i) begin
            if (await_len) begin
                if (word_i != '0) begin
                    remain    <= word_i;
                    await_len <= 1'b0;
                end
            end else begin
                remain <= remain - WORD_W'(1);
                if (remain == WORD_W'(1)) await_len <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uplink_causes.sv
// Sticky interrupt causes. A set in the same cycle as a clear leaves the cause set.
// Assumes set and clear are single-cycle pulses.
module uplink_causes
    import uplink_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_N-1:0] set_i,
    input  logic               clear_i,
    output logic [CAUSE_N-1:0] cause_o,
    output logic               irq_o
);
    logic [CAUSE_N-1:0] cause_q;

    // Hold each cause until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (clear_i ? '0 : cause_q) | set_i;
    end

    assign cause_o = cause_q;
    assign irq_o   = |cause_q;
endmodule

// File: rtl/uplink_framer.sv
// Uplink command packet framer top. Stores every received word in the FIFO,
// tags length words while tracking is enabled, and raises sticky causes.
// Assumes the data-port read strobe lasts one cycle per bus read.
module uplink_framer
    import uplink_pkg::*;
#(
    parameter int FIFO_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ctrl_enable_i,
    input  logic              rd_strobe_i,
    output logic [31:0]       rd_data_o,
    input  logic              fifo_reset_i,
    input  logic              irq_clear_i,
    output logic [CAUSE_N-1:0] status_o,
    output logic              irq_o
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    cmd_entry_t         in_entry, head;
    logic               tag_first, pkt_done, len_err;
    logic               fifo_empty, fifo_full;
    logic [CNT_W-1:0]   fill_cnt;
    logic [CAUSE_N-1:0] cause_set;

    uplink_tracker trk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (ctrl_enable_i),
        .word_valid_i (word_valid_i),
        .word_i       (word_i),
        .first_o      (tag_first),
        .done_o       (pkt_done),
        .len_err_o    (len_err)
    );

    assign in_entry = '{first: tag_first, word: word_i};

    uplink_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (fifo_reset_i),
        .push_i  (word_valid_i),
        .din_i   (in_entry),
        .pop_i   (rd_strobe_i),
        .head_o  (head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full),
        .count_o (fill_cnt)
    );

    // Gather this cycle's cause events
    always_comb begin
        cause_set             = '0;
        cause_set[CAUSE_DONE] = pkt_done;
        cause_set[CAUSE_LERR] = len_err;
        cause_set[CAUSE_OVF]  = word_valid_i && fifo_full;
    end

    uplink_causes cz_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cause_set),
        .clear_i (irq_clear_i),
        .cause_o (status_o),
        .irq_o   (irq_o)
    );

    assign rd_data_o = {!fifo_empty, 14'd0, fifo_empty ? 17'd0 : head};
endmodule

// File: rtl/uplink_framer_chk.sv
// Checker for uplink_framer, attached by bind. Observes ports and the fill count.
module uplink_framer_chk #(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH+1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid_i,
    input logic             ctrl_enable_i,
    input logic             rd_strobe_i,
    input logic             fifo_reset_i,
    input logic             irq_clear_i,
    input logic [31:0]      rd_data_o,
    input logic [2:0]       status_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] fill_cnt
);
    assert_reset_R12: assert property (@(posedge clk)
        !rst_n |=> (status_o == 3'b000 && fill_cnt == '0));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[30:17] == 14'd0);

    assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[31] |-> rd_data_o[16:0] == 17'd0);

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == CNT_W'(DEPTH) && word_valid_i && !rd_strobe_i && !fifo_reset_i)
        |=> (fill_cnt == CNT_W'(DEPTH) && status_o[2]));

    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && fill_cnt == '0 && !word_valid_i && !fifo_reset_i) |=> fill_cnt == '0);

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_reset_i |=> (fill_cnt == '0 && !rd_data_o[31]));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear_i && !word_valid_i) |=> (status_o == 3'b000 && !irq_o));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 3'b000 && !irq_clear_i) |=> irq_o);

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_enable_i && !irq_clear_i) |=> status_o[1:0] == $past(status_o[1:0]));
endmodule

bind uplink_framer uplink_framer_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_valid_i  (word_valid_i),
    .ctrl_enable_i (ctrl_enable_i),
    .rd_strobe_i   (rd_strobe_i),
    .fifo_reset_i  (fifo_reset_i),
    .irq_clear_i   (irq_clear_i),
    .rd_data_o     (rd_data_o),
    .status_o      (status_o),
    .irq_o         (irq_o),
    .fill_cnt      (fill_cnt)
);

// File: tb/uplink_framer_tb_top.sv
module uplink_framer_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        ctrl_enable_i = 1'b0;
    logic        rd_strobe_i = 1'b0;
    logic        fifo_reset_i = 1'b0;
    logic        irq_clear_i = 1'b0;
    logic [31:0] rd_data_o;
    logic [2:0]  status_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model
    logic [16:0] m_q[$];
    bit          m_await = 1'b1;
    int unsigned m_rem = 0;
    logic [2:0]  m_st = 3'b000;

    always #2 clk = ~clk;

    uplink_framer #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_valid_i  (word_valid_i),
        .word_i        (word_i),
        .ctrl_enable_i (ctrl_enable_i),
        .rd_strobe_i   (rd_strobe_i),
        .rd_data_o     (rd_data_o),
        .fifo_reset_i  (fifo_reset_i),
        .irq_clear_i   (irq_clear_i),
        .status_o      (status_o),
        .irq_o         (irq_o)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        logic [31:0] exp_data;
        exp_data = (m_q.size() > 0) ? {1'b1, 14'd0, m_q[0]} : 32'd0;
        check32({tag, " data"}, rd_data_o, exp_data);
        check32({tag, " status"}, {29'd0, status_o}, {29'd0, m_st});
        check32({tag, " irq"}, {31'd0, irq_o}, {31'd0, |m_st});
    endtask

    // Model of one received word at a clock edge
    task automatic model_word(input logic [15:0] w, input bit stored);
        bit f;
        f = 1'b0;
        if (ctrl_enable_i) begin
            if (m_await) begin
                f = 1'b1;
                if (w == 16'd0) m_st[1] = 1'b1;
                else begin m_rem = w; m_await = 1'b0; end
            end else begin
                m_rem--;
                if (m_rem == 0) begin m_st[0] = 1'b1; m_await = 1'b1; end
            end
        end
        if (stored) begin
            if (m_q.size() < DEPTH) m_q.push_back({f, w});
            else m_st[2] = 1'b1;
        end
    endtask

    task automatic send(input logic [15:0] w, input string tag);
        @(negedge clk);
        word_valid_i = 1'b1; word_i = w;
        model_word(w, 1'b1);
        @(negedge clk);
        word_valid_i = 1'b0;
        check_state(tag);
    endtask

    task automatic pop(input string tag);
        @(negedge clk);
        rd_strobe_i = 1'b1;
        if (m_q.size() > 0) void'(m_q.pop_front());
        @(negedge clk);
        rd_strobe_i = 1'b0;
        check_state(tag);
    endtask

    task automatic drain(input string tag);
        while (m_q.size() > 0) pop(tag);
    endtask

    task automatic ack(input string tag);
        @(negedge clk);
        irq_clear_i = 1'b1; m_st = 3'b000;
        @(negedge clk);
        irq_clear_i = 1'b0;
        check_state(tag);
    endtask

    task automatic set_enable(input bit v);
        @(negedge clk);
        ctrl_enable_i = v;
        @(negedge clk);
        if (!v) m_await = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R12 reset");

        // R1 R3: disabled tracker stores plain words, causes stay clear
        for (int i = 0; i < 3; i++) send(16'h0A00 + 16'(i), "R1 R3 disabled store");
        drain("R1 drain disabled");

        // R8: read on empty FIFO has no effect
        pop("R8 empty pop");
        send(16'h5A5A, "R8 after empty pop");
        pop("R8 pop single");

        // R4 R5: sweep packet lengths 1..5, done only on last body word
        set_enable(1'b1);
        for (int len = 1; len <= 5; len++) begin
            send(16'(len), "R5 length word flagged");
            for (int k = 1; k <= len; k++)
                send(16'h1000 * 16'(len) + 16'(k), "R4 body word");
            drain("R1 R3 drain packet");
            ack("R10 ack done");
        end

        // R5: back-to-back packets without draining
        send(16'd1, "R5 back-to-back len"); send(16'hB001, "R4 b2b body");
        send(16'd2, "R5 second length");    send(16'hB002, "R4 mid body");
        send(16'hB003, "R4 second done");
        drain("R5 drain b2b");
        ack("R10 ack b2b");

        // R6: zero length, then a normal packet
        send(16'd0, "R6 zero length");
        send(16'd2, "R6 next is length");
        send(16'hC001, "R6 body"); send(16'hC002, "R6 body done");
        drain("R6 drain");
        ack("R10 ack lerr");

        // R11: abandon a partial packet by disabling
        send(16'd3, "R11 length"); send(16'hD001, "R11 partial");
        set_enable(1'b0);
        send(16'hD002, "R11 disabled word");
        set_enable(1'b1);
        send(16'd1, "R11 relength flagged"); send(16'hD003, "R11 done");
        drain("R11 drain");
        ack("R10 ack r11");

        // R7: overflow while disabled, with wrap-around of pointers
        set_enable(1'b0);
        send(16'hE0E0, "R7 pre"); pop("R7 pre pop");
        for (int i = 0; i < DEPTH + 2; i++) send(16'hE100 + 16'(i), "R7 fill/overflow");
        drain("R7 drain order");
        ack("R10 ack ovf");

        // R9: flush with a same-cycle word; tracker still counts it
        set_enable(1'b1);
        send(16'd2, "R9 length"); send(16'hF001, "R9 body");
        @(negedge clk);
        fifo_reset_i = 1'b1; word_valid_i = 1'b1; word_i = 16'hF002;
        model_word(16'hF002, 1'b0);
        m_q.delete();
        @(negedge clk);
        fifo_reset_i = 1'b0; word_valid_i = 1'b0;
        check_state("R9 flush wins, done counted");

        // R10: acknowledge and a new cause in the same cycle
        @(negedge clk);
        irq_clear_i = 1'b1; word_valid_i = 1'b1; word_i = 16'd0;
        m_st = 3'b000;
        model_word(16'd0, 1'b1);
        @(negedge clk);
        irq_clear_i = 1'b0; word_valid_i = 1'b0;
        check_state("R10 set beats clear");
        ack("R10 final ack");
        drain("R10 drain");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule